// File: doc/BRIEF.md
# Codec power-up sequencer

This block brings an external audio codec from power-off to a working configuration once after every system reset. It switches on codec power, holds the codec's reset-control line for a power-settling interval, releases it and waits a wake-up interval. It then walks through a fixed list of register writes, which it hands one at a time to a write master (a serial control-port engine outside this block). Each write carries a command byte, one or two payload bytes and a length. The write master answers with a done pulse.

The list begins with a soft-reset write to the status register. A hardware reset pulse follows, then a rewrite of the status register with the soft-reset bit cleared. Next come the operating values: two status writes, three direct data writes for volume, tone and peak detection, and six two-byte writes into the extended register bank. All payloads are computed at elaboration from parameters. The wait intervals are parameters in clock cycles. When the last write is acknowledged, the block raises a ready flag, which stays high until the next reset.

Top module: `codec_boot_seq`

## Requirements
- R1: While `rst_n` is low, `pwr_en_o` is 0, `codec_rst_o` is 1, `wr_start_o` is 0 and `ready_o` is 0.
- R2: After reset release, `pwr_en_o` goes to 1 and stays at 1. From the first cycle it is 1, `codec_rst_o` stays at 1 for exactly `PWR_CYC` cycles and then goes to 0.
- R3: After `codec_rst_o` falls, exactly `WAKE_CYC` cycles pass with no write. The first `wr_start_o` comes in the next cycle. No write ever starts while `codec_rst_o` is 1.
- R4: The first write has length 1, command `{DEV_ADDR,2'b10}` (status target) and payload 0x66. In that payload, bit 6 is the soft-reset bit, bits 5:4 = 10 select 256x system clock and bits 3:1 = 011 select 16-bit LSB-justified format.
- R5: After the first write's done pulse, `codec_rst_o` is 1 for exactly `PULSE_CYC` cycles. The next write then starts: status target, length 1, payload 0x26, which is the same byte with the soft-reset bit cleared.
- R6: The next five writes have length 1 and the second byte at 0, in this order:
  - status target, payload 0x26;
  - status target, payload 0xE0 (bit 7 selects the second status register, bits 6 and 5 are the output and input gain switches);
  - data target `{DEV_ADDR,2'b00}`, payload `{2'b00, att}` with att = 63 - VOL_PCT*63/100;
  - data target, payload 0x40 (bass and treble 0);
  - data target, payload 0xA0 (bit 5 is the peak-detect position bit).
- R7: The last six writes have length 2 and use the data target. The first byte is `{2'b11,3'b000,n}` and the second byte is `{3'b111,v}`, for n = 0..5 in order, with v = 4, 4, MIC_SENS, 0, 0, 0.
- R8: `wr_start_o` is a one-cycle pulse. Command, bytes and length hold steady from the start until the done pulse. The next start comes in the cycle after done is seen.
- R9: A pulse on `wr_done_i` while no write is pending has no effect: the wait timings and the written list are unchanged.
- R10: `ready_o` rises in the cycle after the done of the thirteenth write. It then stays at 1, and no further write or codec reset occurs.
- R11: Asserting `rst_n` in the middle of the list aborts the sequence. The next release starts again from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_en_o | output | 1 | Codec power enable |
| codec_rst_o | output | 1 | Codec reset control, 1 = held in reset |
| wr_start_o | output | 1 | One-cycle request to the write master |
| wr_cmd_o | output | 8 | Command byte (device address and target) |
| wr_b0_o | output | 8 | First payload byte |
| wr_b1_o | output | 8 | Second payload byte (0 for one-byte writes) |
| wr_len_o | output | 2 | Payload length, 1 or 2 |
| wr_done_i | input | 1 | Write master completion pulse |
| ready_o | output | 1 | Configuration finished |

## Verification
The bench builds the block with `PWR_CYC` = 20, `WAKE_CYC` = 15 and `PULSE_CYC` = 4. These short waits let it count every wait interval exactly and still run the whole list three times, with a mid-list reset in between. It sets `VOL_PCT` = 75 so that the attenuation field is nonzero (16), which exercises the volume arithmetic. Done latencies are drawn at random, and stray done pulses land in the wake, reset-pulse and issue phases.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

  typedef enum logic [2:0] {
    ST_POWER = 3'd0,
    ST_WAKE  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_PULSE = 3'd4,
    ST_READY = 3'd5
  } seq_state_e;

  localparam int unsigned N_WRITES  = 13;
  localparam int unsigned N_DIRECT  = 7;
  localparam int unsigned N_EXT     = N_WRITES - N_DIRECT;
  localparam int unsigned EXT_SLOTS = 1 << $clog2(N_EXT);
  localparam int unsigned STEP_W    = $clog2(N_WRITES);

  localparam logic [1:0] TGT_DATA   = 2'b00;
  localparam logic [1:0] TGT_STATUS = 2'b10;

  typedef struct packed {
    logic [1:0] len;
    logic [7:0] cmd;
    logic [7:0] b0;
    logic [7:0] b1;
  } wr_req_t;

  // first status register: soft reset, 256x clock, 16-bit LSB-justified
  function automatic logic [7:0] status_a(input logic soft_rst);
    return {1'b0, soft_rst, 2'b10, 3'b011, 1'b0};
  endfunction

  function automatic logic [7:0] status_b();
    return 8'hE0;
  endfunction

  function automatic logic [7:0] volume_byte(input int unsigned pct);
    int unsigned p;
    int unsigned att;
    p   = (pct > 100) ? 100 : pct;
    att = 63 - (p * 63) / 100;
    return {2'b00, att[5:0]};
  endfunction

  function automatic logic [7:0] tone_byte();
    return 8'h40;
  endfunction

  function automatic logic [7:0] mode_byte();
    return 8'hA0;
  endfunction

  function automatic logic [7:0] ext_addr_byte(input logic [2:0] n);
    return {2'b11, 3'b000, n};
  endfunction

  function automatic logic [4:0] ext_value(input int unsigned n, input int unsigned mic);
    logic [4:0] v;
    case (n)
      0, 1:    v = 5'd4;
      2:       v = mic[4:0];
      default: v = 5'd0;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] ext_data_byte(input logic [4:0] v);
    return {3'b111, v};
  endfunction

endpackage

// File: rtl/codec_boot_timer.sv
module codec_boot_timer #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/codec_boot_table.sv
module codec_boot_table
  import codec_boot_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR = 6'h05,
  parameter int unsigned VOL_PCT  = 100,
  parameter int unsigned MIC_SENS = 30
) (
  input  logic [STEP_W-1:0] step_i,
  output wr_req_t           req_o
);

  localparam logic [7:0] CMD_STATUS = {DEV_ADDR, TGT_STATUS};
  localparam logic [7:0] CMD_DATA   = {DEV_ADDR, TGT_DATA};

  logic [7:0] ext_a [EXT_SLOTS];
  logic [7:0] ext_d [EXT_SLOTS];

  for (genvar g = 0; g < EXT_SLOTS; g++) begin : g_ext
    assign ext_a[g] = ext_addr_byte(3'(g));
    assign ext_d[g] = ext_data_byte(ext_value(g, MIC_SENS));
  end

  logic [STEP_W-1:0] ext_idx;
  assign ext_idx = step_i - STEP_W'(N_DIRECT);

  always_comb begin
    req_o = '0;
    case (step_i)
      STEP_W'(0): req_o = '{len: 2'd1, cmd: CMD_STATUS, b0: status_a(1'b1), b1: 8'h00};
      STEP_W'(1),
      STEP_W'(2): req_o = '{len: 2'd1, cmd: CMD_STATUS, b0: status_a(1'b0), b1: 8'h00};
      STEP_W'(3): req_o = '{len: 2'd1, cmd: CMD_STATUS, b0: status_b(),     b1: 8'h00};
      STEP_W'(4): req_o = '{len: 2'd1, cmd: CMD_DATA,   b0: volume_byte(VOL_PCT), b1: 8'h00};
      STEP_W'(5): req_o = '{len: 2'd1, cmd: CMD_DATA,   b0: tone_byte(),    b1: 8'h00};
      STEP_W'(6): req_o = '{len: 2'd1, cmd: CMD_DATA,   b0: mode_byte(),    b1: 8'h00};
      default: begin
        req_o = '{len: 2'd2, cmd: CMD_DATA,
                  b0: ext_a[ext_idx[$clog2(EXT_SLOTS)-1:0]],
                  b1: ext_d[ext_idx[$clog2(EXT_SLOTS)-1:0]]};
      end
    endcase
  end

endmodule

// File: rtl/codec_boot_fsm.sv
module codec_boot_fsm
  import codec_boot_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] WAKE_LD  = '0,
  parameter logic [CNT_W-1:0] PULSE_LD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_zero_i,
  input  logic              wr_done_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic [STEP_W-1:0] step_o,
  output logic              wr_start_o,
  output logic              codec_rst_o,
  output logic              pwr_en_o,
  output logic              ready_o
);

  localparam logic [STEP_W-1:0] STEP_FIRST = '0;
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(N_WRITES - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              pwr_q;
  logic              pwr_en;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    step_en    = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state_q)
      ST_POWER: begin
        if (tmr_zero_i) begin
          state_d    = ST_WAKE;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAKE_LD;
        end
      end
      ST_WAKE: begin
        if (tmr_zero_i) state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wr_done_i) begin
          if (step_q == STEP_LAST) begin
            state_d = ST_READY;
          end else begin
            step_en = 1'b1;
            step_d  = step_q + 1'b1;
            if (step_q == STEP_FIRST) begin
              state_d    = ST_PULSE;
              tmr_load_o = 1'b1;
              tmr_val_o  = PULSE_LD;
            end else begin
              state_d = ST_ISSUE;
            end
          end
        end
      end
      ST_PULSE: begin
        if (tmr_zero_i) state_d = ST_ISSUE;
      end
      ST_READY: begin
        state_d = ST_READY;
      end
      default: begin
        state_d = ST_POWER;
      end
    endcase
  end

  assign pwr_en = ~pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWER;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
    end else if (pwr_en) begin
      pwr_q <= 1'b1;
    end
  end

  assign step_o      = step_q;
  assign wr_start_o  = (state_q == ST_ISSUE);
  assign codec_rst_o = (state_q == ST_POWER) || (state_q == ST_PULSE);
  assign ready_o     = (state_q == ST_READY);
  assign pwr_en_o    = pwr_q;

endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import codec_boot_pkg::*;
#(
  parameter int unsigned PWR_CYC   = 5_000_000,
  parameter int unsigned WAKE_CYC  = 5_000_000,
  parameter int unsigned PULSE_CYC = 50,
  parameter logic [5:0]  DEV_ADDR  = 6'h05,
  parameter int unsigned VOL_PCT   = 100,
  parameter int unsigned MIC_SENS  = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       pwr_en_o,
  output logic       codec_rst_o,
  output logic       wr_start_o,
  output logic [7:0] wr_cmd_o,
  output logic [7:0] wr_b0_o,
  output logic [7:0] wr_b1_o,
  output logic [1:0] wr_len_o,
  input  logic       wr_done_i,
  output logic       ready_o
);

  localparam int unsigned MAX_A   = (PWR_CYC > WAKE_CYC) ? PWR_CYC : WAKE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWR_INIT = CNT_W'(PWR_CYC);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [STEP_W-1:0] step;
  wr_req_t           req;

  codec_boot_timer #(
    .CNT_W (CNT_W),
    .INIT  (PWR_INIT)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  codec_boot_fsm #(
    .CNT_W    (CNT_W),
    .WAKE_LD  (WAKE_LD),
    .PULSE_LD (PULSE_LD)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tmr_zero_i  (tmr_zero),
    .wr_done_i   (wr_done_i),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .step_o      (step),
    .wr_start_o  (wr_start_o),
    .codec_rst_o (codec_rst_o),
    .pwr_en_o    (pwr_en_o),
    .ready_o     (ready_o)
  );

  codec_boot_table #(
    .DEV_ADDR (DEV_ADDR),
    .VOL_PCT  (VOL_PCT),
    .MIC_SENS (MIC_SENS)
  ) u_table (
    .step_i (step),
    .req_o  (req)
  );

  assign wr_cmd_o = req.cmd;
  assign wr_b0_o  = req.b0;
  assign wr_b1_o  = req.b1;
  assign wr_len_o = req.len;

endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_en_o,
  input logic       codec_rst_o,
  input logic       wr_start_o,
  input logic [7:0] wr_cmd_o,
  input logic [7:0] wr_b0_o,
  input logic [7:0] wr_b1_o,
  input logic [1:0] wr_len_o,
  input logic       wr_done_i,
  input logic       ready_o
);

  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (wr_start_o) begin
      pending_q <= 1'b1;
    end else if (wr_done_i) begin
      pending_q <= 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!wr_start_o && !ready_o && codec_rst_o && !pwr_en_o)); // R1

  AST_POWER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_o |=> pwr_en_o); // R2

  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_o |-> !wr_start_o); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o); // R8

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> ($stable(wr_cmd_o) && $stable(wr_b0_o) && $stable(wr_b1_o) && $stable(wr_len_o))); // R8

  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !wr_start_o); // R8

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> (wr_len_o == 2'd1 || wr_len_o == 2'd2)); // R7

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o); // R10

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!wr_start_o && !codec_rst_o && !pending_q)); // R10

endmodule

bind codec_boot_seq codec_boot_chk u_chk (.*);

// File: tb/codec_boot_seq_tb.sv
module codec_boot_seq_tb;

  localparam int unsigned PWR   = 20;
  localparam int unsigned WAKE  = 15;
  localparam int unsigned PULSE = 4;
  localparam logic [5:0]  DEV   = 6'h05;
  localparam int unsigned VOL   = 75;
  localparam int unsigned MIC   = 30;
  localparam int          NWR   = 13;

  logic       clk;
  logic       rst_n;
  logic       pwr_en_o;
  logic       codec_rst_o;
  logic       wr_start_o;
  logic [7:0] wr_cmd_o;
  logic [7:0] wr_b0_o;
  logic [7:0] wr_b1_o;
  logic [1:0] wr_len_o;
  logic       wr_done_i;
  logic       ready_o;

  int n_chk;
  int n_err;

  codec_boot_seq #(
    .PWR_CYC   (PWR),
    .WAKE_CYC  (WAKE),
    .PULSE_CYC (PULSE),
    .DEV_ADDR  (DEV),
    .VOL_PCT   (VOL),
    .MIC_SENS  (MIC)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_en_o    (pwr_en_o),
    .codec_rst_o (codec_rst_o),
    .wr_start_o  (wr_start_o),
    .wr_cmd_o    (wr_cmd_o),
    .wr_b0_o     (wr_b0_o),
    .wr_b1_o     (wr_b1_o),
    .wr_len_o    (wr_len_o),
    .wr_done_i   (wr_done_i),
    .ready_o     (ready_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected {len, cmd, b0, b1} for write number i
  function automatic logic [25:0] exp_wr(input int i);
    logic [7:0] cs;
    logic [7:0] cd;
    int         att;
    int         v;
    cs  = {DEV, 2'b10};
    cd  = {DEV, 2'b00};
    att = 63 - (VOL * 63) / 100;
    case (i)
      0: return {2'd1, cs, 8'h66, 8'h00};
      1, 2: return {2'd1, cs, 8'h26, 8'h00};
      3: return {2'd1, cs, 8'hE0, 8'h00};
      4: return {2'd1, cd, 2'b00, 6'(att), 8'h00};
      5: return {2'd1, cd, 8'h40, 8'h00};
      6: return {2'd1, cd, 8'hA0, 8'h00};
      default: begin
        case (i - 7)
          0, 1: v = 4;
          2: v = MIC;
          default: v = 0;
        endcase
        return {2'd2, cd, 5'b11000, 3'(i - 7), 3'b111, 5'(v)};
      end
    endcase
  endfunction

  function automatic string tag_of(input int i);
    if (i == 0) return "R4";
    if (i == 1) return "R5";
    if (i < 7) return "R6";
    return "R7";
  endfunction

  task automatic run_seq(input int abort_at);
    int n;
    bit ok;
    logic [25:0] got;
    logic [25:0] exp;
    n = 0;
    while (!pwr_en_o) tick();
    // R2: reset held for the power interval
    while (codec_rst_o) begin
      n++;
      if (!pwr_en_o) ok = 0;
      tick();
    end
    chk(n == PWR, "R2", "codec reset length after power on", n, PWR);
    chk(pwr_en_o == 1'b1, "R2", "power enable held", pwr_en_o, 1);
    // R3 wake interval, with a stray done in it (R9)
    n = 0;
    while (!wr_start_o && !codec_rst_o) begin
      wr_done_i = (n == 3);
      n++;
      tick();
    end
    wr_done_i = 1'b0;
    chk(n == WAKE, "R3", "wake cycles before first write", n, WAKE);
    chk(wr_start_o && !codec_rst_o, "R9", "first write after stray done", wr_start_o, 1);
    for (int i = 0; i < NWR; i++) begin
      got = {wr_len_o, wr_cmd_o, wr_b0_o, wr_b1_o};
      exp = exp_wr(i);
      chk(wr_start_o == 1'b1, "R8", $sformatf("start of write %0d", i), wr_start_o, 1);
      chk(got == exp, tag_of(i), $sformatf("fields of write %0d", i), got, exp);
      if (i == abort_at) begin
        rst_n = 1'b0;
        #1;
        chk(!pwr_en_o && codec_rst_o && !ready_o && !wr_start_o, "R11",
            "outputs on mid-list reset", {pwr_en_o, codec_rst_o, ready_o, wr_start_o}, 4'b0100);
        repeat (3) tick();
        rst_n = 1'b1;
        return;
      end
      begin
        int lat;
        lat = 1 + int'($urandom_range(0, 4));
        ok = 1;
        wr_done_i = (i == 5);  // R9: done during the issue cycle
        for (int k = 0; k < lat; k++) begin
          tick();
          wr_done_i = 1'b0;
          if (wr_start_o || ({wr_len_o, wr_cmd_o, wr_b0_o, wr_b1_o} != exp)) ok = 0;
        end
        chk(ok, "R8", $sformatf("write %0d held while pending", i), ok, 1);
      end
      wr_done_i = 1'b1;
      tick();
      wr_done_i = 1'b0;
      if (i == 0) begin
        n = 0;
        while (codec_rst_o && !wr_start_o) begin
          wr_done_i = (n == 1);  // R9: stray done in reset pulse
          n++;
          tick();
        end
        wr_done_i = 1'b0;
        chk(n == PULSE, "R5", "hardware reset pulse length", n, PULSE);
      end else if (i == NWR - 1) begin
        chk(ready_o == 1'b1, "R10", "ready after last done", ready_o, 1);
      end else begin
        chk(ready_o == 1'b0, "R10", $sformatf("not ready after write %0d", i), ready_o, 0);
      end
    end
    ok = 1;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (!ready_o || wr_start_o || codec_rst_o || !pwr_en_o) ok = 0;
    end
    chk(ok, "R10", "ready held with bus idle", ok, 1);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    wr_done_i = 1'b0;
    repeat (3) tick();
    chk(!pwr_en_o && codec_rst_o && !wr_start_o && !ready_o, "R1", "outputs in reset",
        {pwr_en_o, codec_rst_o, wr_start_o, ready_o}, 4'b0100);
    rst_n = 1'b1;
    run_seq(-1);
    rst_n = 1'b0;
    repeat (2) tick();
    chk(!ready_o && codec_rst_o, "R1", "ready cleared by reset", ready_o, 0);
    rst_n = 1'b1;
    run_seq(9);
    // R11: complete restart after the abort
    run_seq(-1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog: ready never reached, actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule